// File: doc/BRIEF.md
# Interval Timer Control Word Decoder

This block sits on the byte-wide write port of a three-channel interval timer and interprets every byte written to the control address. A control word either programs one channel (its counting mode, its byte access pattern and its decimal flag), freezes the count of one channel, or acts as a multi-channel read-back command. That command can freeze the count and/or capture a status byte for any set of channels at once. The block turns each of these into single-cycle per-channel strobes. The counters themselves and the byte sequencing on the data ports stay outside and use these strobes.

For each channel the block keeps the programmed configuration. It also keeps a count-latch pending flag and a status-latch pending flag, plus the captured status byte. A latch request on a channel whose latch of the same kind is still unread is dropped. A pending status byte is handed out on the next read of that channel's data address, and that read frees it. A pending count latch is freed when the external data-port logic reports the latched count as fully read. Reading the control address yields zero.

Top module: `timer_ctrl_decoder`

## Requirements
- R1: After synchronous reset every channel has mode 0, access code 2'b11 and decimal flag 0, and all strobes and pending flags are low.
- R2: A write to address 3 whose bits 7:6 are 0, 1 or 2 and whose bits 5:4 are nonzero loads that channel's access code from bits 5:4, mode from bits 3:1 and decimal flag from bit 0. The channel's mode_stb bit is raised for exactly the following cycle.
- R3: A write to address 3 with bits 7:6 in 0..2 and bits 5:4 equal to 2'b00 raises cnt_latch_stb for that channel and leaves its configuration unchanged.
- R4: A write to address 3 with bits 7:6 equal to 2'b11 is a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2. A low bit 5 requests a count latch and a low bit 4 requests a status latch on each selected channel.
- R5: A count latch request on a channel whose cnt_pending is set raises no strobe. cnt_pending clears one cycle after cnt_rd_done is pulsed for that channel.
- R6: A status latch request on a channel whose sts_pending is set raises no strobe and leaves its captured status byte unchanged.
- R7: A status latch captures the byte {ch_out, ch_null, access[1:0], mode[2:0], decimal} of that channel, with the output level in bit 7 and the decimal flag in bit 0. It uses the configuration and input levels present in the cycle of the request.
- R8: While sts_pending of channel i is set, a read of address i returns the captured status byte with rd_is_status high and clears sts_pending. Otherwise a read of address 0..2 returns zero with rd_is_status low.
- R9: A read of address 3 returns zero with rd_is_status low and changes no pending flag.
- R10: Writes to addresses 0..2 raise no strobe and change no configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write valid |
| wr_addr | input | 2 | Write address; 3 is the control address |
| wr_data | input | 8 | Written byte |
| rd_en | input | 1 | Byte read valid |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Status byte or zero for the current read |
| rd_is_status | output | 1 | The current read returns a status byte |
| ch_out | input | 3 | Output level of each channel |
| ch_null | input | 3 | Null-count flag of each channel (count written, not yet loaded) |
| cnt_rd_done | input | 3 | Latched count of a channel fully read by the data port |
| mode_stb | output | 3 | Channel programmed this cycle |
| cnt_latch_stb | output | 3 | Freeze the count of a channel |
| sts_latch_stb | output | 3 | Status byte of a channel captured |
| cnt_pending | output | 3 | Count latch unread per channel |
| sts_pending | output | 3 | Status latch unread per channel |
| ch_mode | output | 9 | Mode per channel, 3 bits each, channel 0 lowest |
| ch_access | output | 6 | Access code per channel, 2 bits each |
| ch_bcd | output | 3 | Decimal flag per channel |
| ch_status | output | 24 | Captured status byte per channel, 8 bits each |

## Verification
On every cycle the assertions check these properties: at most one channel is programmed per write, and a programming strobe carries the fields of the previous control byte. A configuration changes only under its strobe, and a count-latch strobe never follows a pending count latch. A held status byte stays frozen, a status read frees the latch, and the control address always reads zero. Only the bench scenarios can show the field decoding itself. These cover the read-back channel selection with its active-low latch controls, the exact bit layout of the captured status byte, and the rule that status capture uses the configuration and input levels of the request cycle. They also cover the interplay of repeated latches with reads and done pulses.

// File: rtl/timer_ctrl_pkg.sv
package timer_ctrl_pkg;
    localparam int NCH    = 3;
    localparam int BYTE_W = 8;
    localparam int MODE_W = 3;
    localparam int ACC_W  = 2;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] CTRL_ADDR  = 2'd3;
    localparam logic [1:0]        SEL_RDBACK = 2'b11;
    localparam logic [ACC_W-1:0]  ACC_FREEZE = 2'b00;
    localparam logic [ACC_W-1:0]  ACC_RESET  = 2'b11;

    typedef struct packed {
        logic [ACC_W-1:0]  acc;
        logic [MODE_W-1:0] mode;
        logic              bcd;
    } chan_cfg_t;

    localparam chan_cfg_t CFG_RESET = '{acc: ACC_RESET, mode: '0, bcd: 1'b0};

    function automatic chan_cfg_t cfg_of_word(input logic [BYTE_W-1:0] w);
        chan_cfg_t c;
        c.acc  = w[5:4];
        c.mode = w[3:1];
        c.bcd  = w[0];
        return c;
    endfunction

    function automatic logic [BYTE_W-1:0] status_of(input logic lvl, input logic nul,
                                                    input chan_cfg_t c);
        return {lvl, nul, c.acc, c.mode, c.bcd};
    endfunction
endpackage

// File: rtl/timer_ctrl_decode.sv
module timer_ctrl_decode
    import timer_ctrl_pkg::*;
(
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [NCH-1:0]    prog_req,
    output logic [NCH-1:0]    cnt_req,
    output logic [NCH-1:0]    sts_req
);
    logic is_ctrl;
    logic is_rdback;

    assign is_ctrl   = wr_en && (wr_addr == CTRL_ADDR);
    assign is_rdback = (wr_data[7:6] == SEL_RDBACK);

    always_comb begin
        prog_req = '0;
        cnt_req  = '0;
        sts_req  = '0;
        if (is_ctrl) begin
            for (int i = 0; i < NCH; i++) begin
                if (is_rdback) begin
                    if (wr_data[i+1]) begin
                        cnt_req[i] = ~wr_data[5];
                        sts_req[i] = ~wr_data[4];
                    end
                end else if (wr_data[7:6] == 2'(i)) begin
                    if (wr_data[5:4] == ACC_FREEZE) cnt_req[i]  = 1'b1;
                    else                            prog_req[i] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/timer_ctrl_chan.sv
module timer_ctrl_chan
    import timer_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              prog_req,
    input  logic              cnt_req,
    input  logic              sts_req,
    input  chan_cfg_t         new_cfg,
    input  logic              cnt_done,
    input  logic              sts_done,
    input  logic              lvl,
    input  logic              nul,
    output chan_cfg_t         cfg,
    output logic              prog_stb,
    output logic              cnt_stb,
    output logic              sts_stb,
    output logic              cnt_pend,
    output logic              sts_pend,
    output logic [BYTE_W-1:0] status
);
    logic cnt_take;
    logic sts_take;

    assign cnt_take = cnt_req && !cnt_pend;
    assign sts_take = sts_req && !sts_pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= CFG_RESET;
            prog_stb <= 1'b0;
            cnt_stb  <= 1'b0;
            sts_stb  <= 1'b0;
            cnt_pend <= 1'b0;
            sts_pend <= 1'b0;
            status   <= '0;
        end else begin
            prog_stb <= prog_req;
            cnt_stb  <= cnt_take;
            sts_stb  <= sts_take;
            if (prog_req) cfg <= new_cfg;
            if (sts_take) status <= status_of(lvl, nul, cfg);
            cnt_pend <= (cnt_pend && !cnt_done) || cnt_take;
            sts_pend <= (sts_pend && !sts_done) || sts_take;
        end
    end
endmodule

// File: rtl/timer_ctrl_decoder.sv
module timer_ctrl_decoder
    import timer_ctrl_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [1:0]            wr_addr,
    input  logic [7:0]            wr_data,
    input  logic                  rd_en,
    input  logic [1:0]            rd_addr,
    output logic [7:0]            rd_data,
    output logic                  rd_is_status,
    input  logic [2:0]            ch_out,
    input  logic [2:0]            ch_null,
    input  logic [2:0]            cnt_rd_done,
    output logic [2:0]            mode_stb,
    output logic [2:0]            cnt_latch_stb,
    output logic [2:0]            sts_latch_stb,
    output logic [2:0]            cnt_pending,
    output logic [2:0]            sts_pending,
    output logic [8:0]            ch_mode,
    output logic [5:0]            ch_access,
    output logic [2:0]            ch_bcd,
    output logic [23:0]           ch_status
);
    logic [NCH-1:0] prog_req;
    logic [NCH-1:0] cnt_req;
    logic [NCH-1:0] sts_req;
    logic [NCH-1:0] sts_done;
    chan_cfg_t      word_cfg;

    assign word_cfg = cfg_of_word(wr_data);

    timer_ctrl_decode u_dec (
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .prog_req (prog_req),
        .cnt_req  (cnt_req),
        .sts_req  (sts_req)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        chan_cfg_t cfg_q;

        assign sts_done[g] = rd_en && (rd_addr == 2'(g)) && sts_pending[g];

        timer_ctrl_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .prog_req (prog_req[g]),
            .cnt_req  (cnt_req[g]),
            .sts_req  (sts_req[g]),
            .new_cfg  (word_cfg),
            .cnt_done (cnt_rd_done[g]),
            .sts_done (sts_done[g]),
            .lvl      (ch_out[g]),
            .nul      (ch_null[g]),
            .cfg      (cfg_q),
            .prog_stb (mode_stb[g]),
            .cnt_stb  (cnt_latch_stb[g]),
            .sts_stb  (sts_latch_stb[g]),
            .cnt_pend (cnt_pending[g]),
            .sts_pend (sts_pending[g]),
            .status   (ch_status[g*BYTE_W +: BYTE_W])
        );

        assign ch_mode[g*MODE_W +: MODE_W] = cfg_q.mode;
        assign ch_access[g*ACC_W +: ACC_W] = cfg_q.acc;
        assign ch_bcd[g]                   = cfg_q.bcd;
    end

    always_comb begin
        rd_data      = '0;
        rd_is_status = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (sts_done[i]) begin
                rd_data      = ch_status[i*BYTE_W +: BYTE_W];
                rd_is_status = 1'b1;
            end
        end
    end
endmodule

// File: rtl/timer_ctrl_decoder_chk.sv
module timer_ctrl_decoder_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [1:0]  wr_addr,
    input logic [7:0]  wr_data,
    input logic        rd_en,
    input logic [1:0]  rd_addr,
    input logic [7:0]  rd_data,
    input logic        rd_is_status,
    input logic [2:0]  cnt_rd_done,
    input logic [2:0]  mode_stb,
    input logic [2:0]  cnt_latch_stb,
    input logic [2:0]  sts_pending,
    input logic [2:0]  cnt_pending,
    input logic [8:0]  ch_mode,
    input logic [5:0]  ch_access,
    input logic [23:0] ch_status
);
    p_one_prog_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mode_stb));

    p_ctrl_read_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_addr == 2'd3) |-> (rd_data == 8'h00 && !rd_is_status));

    for (genvar g = 0; g < 3; g++) begin : g_p
        p_prog_fields_r2: assert property (@(posedge clk) disable iff (rst)
            mode_stb[g] |-> (ch_mode[g*3 +: 3] == $past(wr_data[3:1])
                             && ch_access[g*2 +: 2] == $past(wr_data[5:4])));

        p_cfg_hold_r3: assert property (@(posedge clk) disable iff (rst)
            !mode_stb[g] |-> ($stable(ch_mode[g*3 +: 3]) && $stable(ch_access[g*2 +: 2])));

        p_no_relatch_r5: assert property (@(posedge clk) disable iff (rst)
            cnt_latch_stb[g] |-> (!$past(cnt_pending[g]) && cnt_pending[g]));

        p_status_frozen_r6: assert property (@(posedge clk) disable iff (rst)
            ($past(sts_pending[g]) && sts_pending[g]) |-> $stable(ch_status[g*8 +: 8]));

        p_status_read_frees_r8: assert property (@(posedge clk) disable iff (rst)
            (rd_en && rd_addr == 2'(g) && sts_pending[g]) |=> !sts_pending[g]);
    end
endmodule

bind timer_ctrl_decoder timer_ctrl_decoder_chk u_chk (.*);

// File: tb/timer_ctrl_decoder_test.sv
module timer_ctrl_decoder_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        rd_is_status;
    logic [2:0]  ch_out = '0;
    logic [2:0]  ch_null = '0;
    logic [2:0]  cnt_rd_done = '0;
    logic [2:0]  mode_stb, cnt_latch_stb, sts_latch_stb, cnt_pending, sts_pending;
    logic [8:0]  ch_mode;
    logic [5:0]  ch_access;
    logic [2:0]  ch_bcd;
    logic [23:0] ch_status;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    timer_ctrl_decoder uut (.*);

    // behavioural reference state
    bit [2:0] m_mode [3];
    bit [1:0] m_acc  [3];
    bit       m_bcd  [3];
    bit       m_cp [3], m_sp [3];
    bit       m_ps [3], m_cs [3], m_ss [3];
    bit [7:0] m_sb [3];
    bit       p_req, c_req, s_req;

    always @(posedge clk) begin
        for (int i = 0; i < 3; i++) begin
            if (rst) begin
                m_mode[i] = 0; m_acc[i] = 2'b11; m_bcd[i] = 0;
                m_cp[i] = 0; m_sp[i] = 0; m_ps[i] = 0; m_cs[i] = 0; m_ss[i] = 0; m_sb[i] = 0;
            end else begin
                p_req = 0; c_req = 0; s_req = 0;
                if (wr_en && wr_addr == 3) begin
                    if (wr_data[7:6] == 3) begin
                        if (wr_data[i+1]) begin
                            c_req = !wr_data[5];
                            s_req = !wr_data[4];
                        end
                    end else if (int'(wr_data[7:6]) == i) begin
                        if (wr_data[5:4] == 0) c_req = 1;
                        else p_req = 1;
                    end
                end
                m_ps[i] = p_req;
                m_cs[i] = c_req && !m_cp[i];
                m_ss[i] = s_req && !m_sp[i];
                if (m_ss[i])
                    m_sb[i] = {ch_out[i], ch_null[i], m_acc[i], m_mode[i], m_bcd[i]};
                m_cp[i] = (m_cp[i] && !cnt_rd_done[i]) || m_cs[i];
                m_sp[i] = (m_sp[i] && !(rd_en && int'(rd_addr) == i)) || m_ss[i];
                if (p_req) begin
                    m_acc[i] = wr_data[5:4]; m_mode[i] = wr_data[3:1]; m_bcd[i] = wr_data[0];
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the reference
    always @(negedge clk) begin
        if (!rst) begin
            logic [2:0] e_ps, e_cs, e_ss, e_cp, e_sp, e_bcd;
            logic [8:0] e_mode;
            logic [5:0] e_acc;
            logic [23:0] e_sb;
            logic [7:0] e_rd;
            logic e_isst;
            e_rd = 0; e_isst = 0;
            for (int i = 0; i < 3; i++) begin
                e_ps[i] = m_ps[i]; e_cs[i] = m_cs[i]; e_ss[i] = m_ss[i];
                e_cp[i] = m_cp[i]; e_sp[i] = m_sp[i]; e_bcd[i] = m_bcd[i];
                e_mode[i*3 +: 3] = m_mode[i];
                e_acc[i*2 +: 2] = m_acc[i];
                e_sb[i*8 +: 8] = m_sb[i];
                if (rd_en && int'(rd_addr) == i && m_sp[i]) begin
                    e_rd = m_sb[i]; e_isst = 1;
                end
            end
            chk("R2 mode_stb", 32'(mode_stb), 32'(e_ps));
            chk("R3 cnt_latch_stb", 32'(cnt_latch_stb), 32'(e_cs));
            chk("R4 sts_latch_stb", 32'(sts_latch_stb), 32'(e_ss));
            chk("R5 cnt_pending", 32'(cnt_pending), 32'(e_cp));
            chk("R6 sts_pending", 32'(sts_pending), 32'(e_sp));
            chk("R2 config", {14'd0, ch_mode, ch_access, ch_bcd}, {14'd0, e_mode, e_acc, e_bcd});
            chk("R7 ch_status", 32'(ch_status), 32'(e_sb));
            chk("R8 rd_data", {23'd0, rd_is_status, rd_data}, {23'd0, e_isst, e_rd});
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic rd_start(input logic [1:0] a);
        @(posedge clk); #1;
        rd_en = 1; rd_addr = a;
        #1;
    endtask

    task automatic rd_end();
        @(posedge clk); #1;
        rd_en = 0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        #1;
        // R1 reset state
        chk("R1 mode", 32'(ch_mode), 0);
        chk("R1 access", 32'(ch_access), 32'h3f);
        chk("R1 pending", {cnt_pending, sts_pending, ch_bcd}, 0);
        // R2 programming
        wr(3, 8'h35);
        chk("R2 stb ch0", 32'(mode_stb), 32'b001);
        chk("R2 ch0 cfg", {ch_access[1:0], ch_mode[2:0], ch_bcd[0]}, 32'b11_010_1);
        wr(3, 8'h92);
        chk("R2 stb ch2", 32'(mode_stb), 32'b100);
        chk("R2 ch2 cfg", {ch_access[5:4], ch_mode[8:6], ch_bcd[2]}, 32'b01_001_0);
        // R10 data-port writes ignored
        wr(0, 8'h55);
        chk("R10 no strobe", {mode_stb, cnt_latch_stb, sts_latch_stb}, 0);
        chk("R10 cfg kept", 32'(ch_mode), 32'b001_000_010);
        // R3 count latch on ch1
        wr(3, 8'h40);
        chk("R3 latch ch1", 32'(cnt_latch_stb), 32'b010);
        chk("R3 cfg kept", 32'(ch_access[3:2]), 32'b11);
        // R5 repeat ignored, then freed
        wr(3, 8'h40);
        chk("R5 repeat ignored", 32'(cnt_latch_stb), 0);
        @(posedge clk); #1 cnt_rd_done = 3'b010;
        @(posedge clk); #1 cnt_rd_done = 0;
        chk("R5 freed", 32'(cnt_pending), 0);
        wr(3, 8'h40);
        chk("R5 relatch", 32'(cnt_latch_stb), 32'b010);
        // R4 / R7 status read-back on all channels
        ch_out = 3'b101; ch_null = 3'b010;
        wr(3, 8'hEE);
        chk("R4 sts all", 32'(sts_latch_stb), 32'b111);
        chk("R4 no cnt", 32'(cnt_latch_stb), 0);
        chk("R7 ch0 status", 32'(ch_status[7:0]), 32'hB5);
        chk("R7 ch1 status", 32'(ch_status[15:8]), 32'h70);
        chk("R7 ch2 status", 32'(ch_status[23:16]), 32'h92);
        // R6 repeat status ignored
        ch_out = 3'b000;
        wr(3, 8'hEE);
        chk("R6 no strobe", 32'(sts_latch_stb), 0);
        chk("R6 ch0 kept", 32'(ch_status[7:0]), 32'hB5);
        // R8 status read
        rd_start(0);
        chk("R8 status byte", {rd_is_status, rd_data}, {1'b1, 8'hB5});
        rd_end();
        rd_start(0);
        chk("R8 freed read", {rd_is_status, rd_data}, 0);
        rd_end();
        // R9 control address read
        rd_start(3);
        chk("R9 zero", {rd_is_status, rd_data}, 0);
        rd_end();
        chk("R9 pend kept", 32'(sts_pending), 32'b110);
        // R4 count read-back on ch0 and ch2 (ch1 still pending)
        wr(3, 8'hDA);
        chk("R4 cnt ch0 ch2", 32'(cnt_latch_stb), 32'b101);
        chk("R4 no sts", 32'(sts_latch_stb), 0);
        repeat (3) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule